// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block drives the control strobes of an external memory bus for one access at a time. A bus master raises a request with a chip-select space index (0 to 3) and a read/write flag. The block then runs the access: it opens the address phase, lowers the chip-select of the requested space, sets the direction line, pulses the read or the write strobe, releases chip-select and finally acknowledges.

The block is clocked at twice the system clock rate, so one period of `clk` (a "tick") is half a system clock. This lets write strobe setup and hold sit on half-period boundaries. An internal phase bit marks system clock boundaries, and an access can start only on one of them. Configuration inputs choose one space that gets a delayed chip-select and direction, one space that gets programmable write strobe setup and hold, and a read hold value for each space. A per-space recovery-enable input turns all adjustment off for that space. Every field is captured when an access starts.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: After reset all `cs_n` bits, `rd_n` and `wr_n` are high, `rw_dir` is high, and `addr_phase` and `ack` are low.
- R2: Basic timing (no adjustment applies): `cs_n[space]` falls in the same tick `addr_phase` rises. The strobe (`rd_n` for reads, `wr_n` for writes) falls in that same tick, stays low for 4 ticks (two system clocks) and rises together with `cs_n[space]`.
- R3: When the space equals `cfg_cs_sel`, chip-select and direction assert `2*cfg_tac` ticks after `addr_phase` rises (codes 0, 1, 2). The reserved code 3 acts as 0. The strobe falls together with chip-select unless R4 also applies.
- R4: For a write to the space equal to `cfg_wr_sel`, `wr_n` falls `2*cfg_tcw+1` ticks after chip-select falls (0.5, 1.5, 2.5 or 3.5 system clocks). Chip-select rises the same number of ticks after `wr_n` rises. Reads to that space are not affected.
- R5: For a read, chip-select rises `2*h` ticks after `rd_n` rises. `h` is the 2-bit code in `cfg_rd_hold[2*s+1:2*s]` for space s, and it applies to every space.
- R6: When `rec_en[space]` is high, the access uses basic timing (R2) whatever the configuration fields hold.
- R7: `ack` is high for exactly 2 ticks, starting in the tick in which chip-select rises. `addr_phase` is low from that tick on, and no new access starts before `ack` ends.
- R8: Configuration fields are captured when an access starts. Changes made during an access do not alter its timing.
- R9: At most one `cs_n` bit is low at a time, and it is the requested space. `rw_dir` is 0 for a write and 1 for a read while that chip-select is low. The strobe of the other direction stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| req_space | input | 2 | Chip-select space index of the request |
| req_write | input | 1 | 1 = write access, 0 = read |
| ack | output | 1 | Access complete, high for 2 ticks |
| cfg_cs_sel | input | 2 | Space with delayed chip-select/direction |
| cfg_tac | input | 2 | Address-to-chip-select delay code |
| cfg_wr_sel | input | 2 | Space with adjusted write strobe |
| cfg_tcw | input | 2 | Write strobe setup/hold code |
| cfg_rd_hold | input | 8 | Read hold code, 2 bits per space |
| rec_en | input | 4 | Per-space recovery enable, forces basic timing |
| addr_phase | output | 1 | High while the address is being driven |
| cs_n | output | 4 | Active-low chip-selects, one per space |
| rw_dir | output | 1 | Direction line, 0 = write |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Each access is measured at the ports as tick offsets from the rise of `addr_phase`: chip-select fall, strobe fall, strobe width, chip-select rise and the start and length of `ack`. Reads and writes are run on spaces that are not selected, which fixes the basic shape. The same spaces are then selected with every delay code, including the reserved one, which shows whether setup, write setup/hold and read hold are each placed by their own field and applied to the right space and direction. Recovery-enable runs repeat adjusted settings with the bit set and cleared. A final access rewrites the configuration while it is in flight, which shows whether the fields were captured at the start.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PRE   = 3'd2,
    ST_STRB  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_ACK   = 3'd5
  } seq_st_t;

endpackage

// File: rtl/bst_timing_calc.sv
module bst_timing_calc #(
  parameter int NUM_SPACES = 4,
  parameter int SEL_W      = 2,
  parameter int CODE_W     = 2,
  parameter int CNT_W      = 4
) (
  input  logic [SEL_W-1:0]             space,
  input  logic                         write,
  input  logic [SEL_W-1:0]             cs_sel,
  input  logic [CODE_W-1:0]            tac,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [CODE_W-1:0]            tcw,
  input  logic [NUM_SPACES*CODE_W-1:0] rd_hold,
  input  logic [NUM_SPACES-1:0]        rec_en,
  output logic [CNT_W-1:0]             setup_t,
  output logic [CNT_W-1:0]             pre_t,
  output logic [CNT_W-1:0]             hold_t
);
  localparam logic [CODE_W-1:0] TAC_RSVD = '1;

  logic [CODE_W-1:0] rd_codes [NUM_SPACES];
  logic [CODE_W-1:0] rd_code;
  logic              adj_ok, adj_cs, adj_wr, adj_rd;

  // unpack per-space read hold codes
  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_rd
    assign rd_codes[s] = rd_hold[s*CODE_W +: CODE_W];
  end

  assign rd_code = rd_codes[space];
  assign adj_ok  = !rec_en[space];
  assign adj_cs  = adj_ok && (space == cs_sel);
  assign adj_wr  = adj_ok && write && (space == wr_sel);
  assign adj_rd  = adj_ok && !write;

  always_comb begin
    setup_t = '0;
    pre_t   = '0;
    hold_t  = '0;
    if (adj_cs && tac != TAC_RSVD) setup_t = CNT_W'({tac, 1'b0});
    if (adj_wr) begin
      pre_t  = CNT_W'({tcw, 1'b1});
      hold_t = CNT_W'({tcw, 1'b1});
    end else if (adj_rd) begin
      hold_t = CNT_W'({rd_code, 1'b0});
    end
  end
endmodule

// File: rtl/bst_sequencer.sv
module bst_sequencer
  import bst_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int CNT_W      = 4,
  parameter int STRB_TICKS = 4,
  parameter int ACK_TICKS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [SEL_W-1:0] req_space,
  input  logic             req_write,
  input  logic [CNT_W-1:0] setup_t,
  input  logic [CNT_W-1:0] pre_t,
  input  logic [CNT_W-1:0] hold_t,
  output seq_st_t          st,
  output logic [SEL_W-1:0] space,
  output logic             write
);
  localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STRB_TICKS - 1);
  localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(ACK_TICKS - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pre_q, pre_d, hold_q, hold_d;
  logic [SEL_W-1:0] space_q, space_d;
  logic             write_q, write_d, phase_q, phase_d;
  logic             accept, cnt_done;

  assign accept   = (st_q == ST_IDLE) && req && !phase_q;
  assign cnt_done = (cnt_q == '0);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    hold_d  = hold_q;
    space_d = space_q;
    write_d = write_q;
    phase_d = !phase_q;
    if (st_q != ST_IDLE && !cnt_done) cnt_d = cnt_q - ONE;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        space_d = req_space;
        write_d = req_write;
        pre_d   = pre_t;
        hold_d  = hold_t;
        if (setup_t != '0) begin
          st_d = ST_SETUP; cnt_d = setup_t - ONE;
        end else if (pre_t != '0) begin
          st_d = ST_PRE; cnt_d = pre_t - ONE;
        end else begin
          st_d = ST_STRB; cnt_d = STRB_LAST;
        end
      end
      ST_SETUP: if (cnt_done) begin
        if (pre_q != '0) begin
          st_d = ST_PRE; cnt_d = pre_q - ONE;
        end else begin
          st_d = ST_STRB; cnt_d = STRB_LAST;
        end
      end
      ST_PRE: if (cnt_done) begin
        st_d = ST_STRB; cnt_d = STRB_LAST;
      end
      ST_STRB: if (cnt_done) begin
        if (hold_q != '0) begin
          st_d = ST_HOLD; cnt_d = hold_q - ONE;
        end else begin
          st_d = ST_ACK; cnt_d = ACK_LAST;
        end
      end
      ST_HOLD: if (cnt_done) begin
        st_d = ST_ACK; cnt_d = ACK_LAST;
      end
      ST_ACK: if (cnt_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pre_q   <= '0;
      hold_q  <= '0;
      space_q <= '0;
      write_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
      hold_q  <= hold_d;
      space_q <= space_d;
      write_q <= write_d;
      phase_q <= phase_d;
    end
  end

  assign st    = st_q;
  assign space = space_q;
  assign write = write_q;

  // R2
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STRB) |-> (cnt_q <= STRB_LAST));

  // R8
  space_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && st_d != ST_IDLE) |=> $stable(space_q) && $stable(write_q));
endmodule

// File: rtl/bst_strobe_decode.sv
module bst_strobe_decode
  import bst_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int SEL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seq_st_t               st,
  input  logic [SEL_W-1:0]      space,
  input  logic                  write,
  output logic                  addr_phase,
  output logic [NUM_SPACES-1:0] cs_n,
  output logic                  rw_dir,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic                  ack
);
  logic cs_on, strb_on;

  assign cs_on   = (st == ST_PRE) || (st == ST_STRB) || (st == ST_HOLD);
  assign strb_on = (st == ST_STRB);

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_cs
    assign cs_n[s] = !(cs_on && (space == SEL_W'(s)));
  end

  assign addr_phase = cs_on || (st == ST_SETUP);
  assign rw_dir     = !(cs_on && write);
  assign rd_n       = !(strb_on && !write);
  assign wr_n       = !(strb_on && write);
  assign ack        = (st == ST_ACK);

  // R9
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (~&cs_n) && addr_phase);

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (&cs_n) && !addr_phase && rd_n && wr_n);
endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
  import bst_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int CODE_W     = 2,
  parameter int STRB_TICKS = 4,
  parameter int ACK_TICKS  = 2,
  localparam int SEL_W     = $clog2(NUM_SPACES),
  localparam int CNT_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req,
  input  logic [SEL_W-1:0]             req_space,
  input  logic                         req_write,
  output logic                         ack,
  input  logic [SEL_W-1:0]             cfg_cs_sel,
  input  logic [CODE_W-1:0]            cfg_tac,
  input  logic [SEL_W-1:0]             cfg_wr_sel,
  input  logic [CODE_W-1:0]            cfg_tcw,
  input  logic [NUM_SPACES*CODE_W-1:0] cfg_rd_hold,
  input  logic [NUM_SPACES-1:0]        rec_en,
  output logic                         addr_phase,
  output logic [NUM_SPACES-1:0]        cs_n,
  output logic                         rw_dir,
  output logic                         rd_n,
  output logic                         wr_n
);
  logic             rst_meta_q, rst_sync_q;
  logic [CNT_W-1:0] setup_t, pre_t, hold_t;
  seq_st_t          st;
  logic [SEL_W-1:0] cur_space;
  logic             cur_write;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bst_timing_calc #(
    .NUM_SPACES(NUM_SPACES), .SEL_W(SEL_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_calc (
    .space(req_space), .write(req_write),
    .cs_sel(cfg_cs_sel), .tac(cfg_tac),
    .wr_sel(cfg_wr_sel), .tcw(cfg_tcw),
    .rd_hold(cfg_rd_hold), .rec_en(rec_en),
    .setup_t(setup_t), .pre_t(pre_t), .hold_t(hold_t)
  );

  bst_sequencer #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .STRB_TICKS(STRB_TICKS), .ACK_TICKS(ACK_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .req(req), .req_space(req_space), .req_write(req_write),
    .setup_t(setup_t), .pre_t(pre_t), .hold_t(hold_t),
    .st(st), .space(cur_space), .write(cur_write)
  );

  bst_strobe_decode #(
    .NUM_SPACES(NUM_SPACES), .SEL_W(SEL_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_sync_q),
    .st(st), .space(cur_space), .write(cur_write),
    .addr_phase(addr_phase), .cs_n(cs_n), .rw_dir(rw_dir),
    .rd_n(rd_n), .wr_n(wr_n), .ack(ack)
  );

  // R7
  ack_width_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(ack) |=> ack);

  // R7
  ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(ack) |-> $past(~&cs_n));

  // R2
  strobe_min_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($fell(rd_n) || $fell(wr_n)) |=> (!rd_n || !wr_n));
endmodule

// File: tb/ext_bus_strobe_gen_bench.sv
module ext_bus_strobe_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] req_space = '0;
  logic       req_write = 1'b0;
  logic       ack;
  logic [1:0] cfg_cs_sel = 2'd1, cfg_tac = '0, cfg_wr_sel = 2'd2, cfg_tcw = '0;
  logic [7:0] cfg_rd_hold = '0;
  logic [3:0] rec_en = '0;
  logic       addr_phase, rw_dir, rd_n, wr_n;
  logic [3:0] cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = !clk;

  ext_bus_strobe_gen u_ext_bus_strobe_gen (
    .clk(clk), .rst_n(rst_n), .req(req), .req_space(req_space),
    .req_write(req_write), .ack(ack), .cfg_cs_sel(cfg_cs_sel),
    .cfg_tac(cfg_tac), .cfg_wr_sel(cfg_wr_sel), .cfg_tcw(cfg_tcw),
    .cfg_rd_hold(cfg_rd_hold), .rec_en(rec_en), .addr_phase(addr_phase),
    .cs_n(cs_n), .rw_dir(rw_dir), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // one access; offsets in ticks from the rise of addr_phase
  task automatic run_access(input int sp, input bit wr, input int e_setup,
                            input int e_pre, input int e_hold, input bit poke,
                            input string rq);
    int cs_lo = -1, st_lo = -1, st_hi = -1, cs_hi = -1, ack_i = -1;
    int guard = 0;
    bit bad = 0, ap_bad = 0;
    @(negedge clk);
    req_space = 2'(sp);
    req_write = wr;
    req = 1'b1;
    while (!addr_phase && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(addr_phase, rq, "access start", int'(addr_phase), 1);
    for (int i = 0; i < 64 && ack_i < 0; i++) begin
      logic strb, other;
      if (poke && i == 1) begin
        cfg_tac = '0; cfg_tcw = '0; cfg_rd_hold = '0;
        cfg_cs_sel = 2'(sp + 1); cfg_wr_sel = 2'(sp + 1);
      end
      strb  = wr ? wr_n : rd_n;
      other = wr ? rd_n : wr_n;
      if (cs_lo < 0 && !cs_n[sp]) cs_lo = i;
      if (st_lo < 0 && !strb) st_lo = i;
      if (st_lo >= 0 && st_hi < 0 && strb) st_hi = i;
      if (cs_lo >= 0 && cs_hi < 0 && cs_n[sp]) cs_hi = i;
      if (!other) bad = 1;
      for (int k = 0; k < 4; k++) if (k != sp && !cs_n[k]) bad = 1;
      if (!cs_n[sp] && rw_dir != !wr) bad = 1;
      if (ack) begin
        ack_i = i;
        req = 1'b0;
        if (addr_phase) ap_bad = 1;
      end
      @(negedge clk);
    end
    chk(cs_lo == e_setup, rq, "cs fall tick", cs_lo, e_setup);
    chk(st_lo == e_setup + e_pre, rq, "strobe fall tick", st_lo, e_setup + e_pre);
    chk(st_hi - st_lo == 4, "R2", "strobe width", st_hi - st_lo, 4);
    chk(cs_hi == st_hi + e_hold, rq, "cs rise tick", cs_hi, st_hi + e_hold);
    chk(ack_i == cs_hi && !ap_bad, "R7", "ack start tick", ack_i, cs_hi);
    chk(ack === 1'b1, "R7", "ack second tick", int'(ack), 1);
    chk(bad == 0, "R9", "select/direction/other strobe", int'(bad), 0);
    @(negedge clk);
    chk(ack === 1'b0 && !addr_phase, "R7", "ack ended, bus idle", int'(ack), 0);
  endtask

  task automatic t_reset;
    chk(cs_n == 4'hF && rd_n && wr_n && rw_dir && !addr_phase && !ack,
        "R1", "reset outputs", int'({cs_n, rd_n, wr_n, rw_dir, addr_phase, ack}),
        int'(9'b1111_1110_0));
  endtask

  task automatic t_basic;
    cfg_cs_sel = 2'd1; cfg_wr_sel = 2'd2; cfg_tac = 2'd2; cfg_tcw = 2'd3;
    run_access(0, 1'b0, 0, 0, 0, 1'b0, "R2");
    run_access(3, 1'b1, 0, 0, 0, 1'b0, "R2");
  endtask

  task automatic t_setup;
    cfg_cs_sel = 2'd1; cfg_wr_sel = 2'd2; cfg_tcw = 2'd0;
    cfg_tac = 2'd1; run_access(1, 1'b0, 2, 0, 0, 1'b0, "R3");
    cfg_tac = 2'd2; run_access(1, 1'b0, 4, 0, 0, 1'b0, "R3");
    cfg_tac = 2'd3; run_access(1, 1'b0, 0, 0, 0, 1'b0, "R3");
    cfg_tac = 2'd2; run_access(1, 1'b1, 4, 0, 0, 1'b0, "R3");
  endtask

  task automatic t_write_adj;
    cfg_cs_sel = 2'd1; cfg_tac = 2'd0; cfg_wr_sel = 2'd2;
    cfg_tcw = 2'd0; run_access(2, 1'b1, 0, 1, 1, 1'b0, "R4");
    cfg_tcw = 2'd3; run_access(2, 1'b1, 0, 7, 7, 1'b0, "R4");
    cfg_cs_sel = 2'd2; cfg_tac = 2'd1; cfg_tcw = 2'd1;
    run_access(2, 1'b1, 2, 3, 3, 1'b0, "R4");
    cfg_cs_sel = 2'd1; cfg_tac = 2'd0; cfg_tcw = 2'd3;
    run_access(2, 1'b0, 0, 0, 0, 1'b0, "R4");
  endtask

  task automatic t_read_hold;
    cfg_cs_sel = 2'd1; cfg_tac = 2'd0; cfg_wr_sel = 2'd2; cfg_tcw = 2'd0;
    cfg_rd_hold = 8'b11_10_00_01;
    run_access(0, 1'b0, 0, 0, 2, 1'b0, "R5");
    run_access(3, 1'b0, 0, 0, 6, 1'b0, "R5");
    run_access(2, 1'b0, 0, 0, 4, 1'b0, "R5");
    run_access(1, 1'b0, 0, 0, 0, 1'b0, "R5");
  endtask

  task automatic t_recovery;
    rec_en = 4'b1100;
    cfg_cs_sel = 2'd2; cfg_tac = 2'd2; cfg_wr_sel = 2'd2; cfg_tcw = 2'd3;
    run_access(2, 1'b1, 0, 0, 0, 1'b0, "R6");
    run_access(3, 1'b0, 0, 0, 0, 1'b0, "R6");
    run_access(0, 1'b0, 0, 0, 2, 1'b0, "R6");
    rec_en = 4'b0000;
  endtask

  task automatic t_capture;
    cfg_cs_sel = 2'd1; cfg_tac = 2'd2; cfg_wr_sel = 2'd1; cfg_tcw = 2'd2;
    run_access(1, 1'b1, 4, 5, 5, 1'b1, "R8");
  endtask

  initial begin
    for (int w = 0; w < 20000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_setup();
    t_write_adj();
    t_read_hold();
    t_recovery();
    t_capture();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule